// File: doc/BRIEF.md
# Shared PCI Interrupt Line Router

This block steers four shared PCI interrupt request lines onto the sixteen inputs of a legacy interrupt controller. Each shared line owns one byte-wide routing register. The low bits of a routing value select a controller input, and any value of sixteen or above takes the line out of service. Several shared lines may select the same controller input. That input is then the wired-OR of their levels.

The routing registers are written through a byte-addressed configuration port. The port carries a 32-bit data word, a dword-aligned address and a byte-enable mask. A separate combinational read port returns the stored bytes unchanged. The block keeps a registered level map with one bit per (controller input, shared line) pair. The map is rebuilt every cycle from the current routes and input levels. As a result, a route change or a level change reaches the outputs one clock later and leaves no stale bits behind.

A small combinational helper also gives the shared line that a device interrupt pin lands on, from the slot field of the device/function number.

Top module: `pirq_pic_router`

## Requirements
- R1: During reset and after it, every routing register reads 0x80 and all sixteen outputs are low, whatever the input levels.
- R2: A write whose address bits [7:2] match the routing dword (byte address 0x60; address bits [1:0] are ignored) stores data byte i into the routing register of shared line i (A=0, B=1, C=2, D=3), but only for lanes whose byte-enable bit i is set. Other lanes keep their value.
- R3: A write to any other dword leaves every routing register unchanged. A read of any other dword returns zero.
- R4: A read of the routing dword returns the four routing bytes exactly as written, with line A in bits [7:0] and line D in bits [31:24].
- R5: When a shared line's routing value is below 16, output number (value mod 16) follows that line's level. It is updated on the first clock edge that samples the changed level.
- R6: When a shared line's routing value is 16 or more, its level has no effect on any output.
- R7: An output routed from several shared lines is high while any of them is high, and low only when all of them are low.
- R8: After a routing write, the old output drops and the new output rises on the second clock edge counted from the edge that stores the write.
- R9: Device pin intx (0..3) in slot s = devfn[7:3] maps to shared line (intx + s - 1) mod 4, for example slot 0 pin 0 to line 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_wr_en_i | input | 1 | Configuration write strobe |
| cfg_wr_addr_i | input | 8 | Configuration write byte address |
| cfg_wr_data_i | input | 32 | Configuration write data |
| cfg_wr_be_i | input | 4 | Byte-lane enables of the write |
| cfg_rd_addr_i | input | 8 | Configuration read byte address |
| cfg_rd_data_o | output | 32 | Combinational read data |
| pirq_level_i | input | 4 | Levels of shared lines A..D |
| dev_devfn_i | input | 8 | Device/function number for the pin helper |
| dev_intx_i | input | 2 | Device interrupt pin 0..3 |
| dev_pirq_o | output | 2 | Shared line reached by that pin |
| irq_o | output | 16 | Controller input levels |

## Verification
The assertions check four things on every cycle. A routing byte changes only under its own enabled lane. A disabled line leaves its map column empty. An enabled, high line sets exactly the map bit its previous route chose, and each column holds at most one bit. No output is high unless some input was high the cycle before. Other behaviour can only be shown by the bench's scenarios: the exact output pattern for a given set of routes and levels, the wired-OR holding until the last sharer drops, the two-edge latency of a reroute, the read-back values, and the slot-to-line mapping.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;

   localparam int unsigned ROUTE_W = 8;   // one routing byte per lane
   localparam int unsigned LANES   = 4;   // byte lanes in a config dword

   // Shared line hit by device pin intx in the given slot: (intx + slot - 1) mod n
   function automatic int unsigned slot_to_pirq(input int unsigned slot,
                                                input int unsigned intx,
                                                input int unsigned n);
      return (intx + slot + n - 1) % n;
   endfunction

endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
   import pirq_router_pkg::*;
#(
   parameter int unsigned           NUM_PIRQ    = 4,
   parameter int unsigned           ADDR_W      = 8,
   parameter logic [ADDR_W-1:0]     ROUTE_BASE  = 8'h60,
   parameter logic [ROUTE_W-1:0]    ROUTE_RESET = 8'h80
) (
   input  logic                              clk_i,
   input  logic                              rst_ni,
   input  logic                              wr_en_i,
   input  logic [ADDR_W-1:0]                 wr_addr_i,
   input  logic [LANES*ROUTE_W-1:0]          wr_data_i,
   input  logic [LANES-1:0]                  wr_be_i,
   input  logic [ADDR_W-1:0]                 rd_addr_i,
   output logic [LANES*ROUTE_W-1:0]          rd_data_o,
   output logic [NUM_PIRQ-1:0][ROUTE_W-1:0]  route_o
);

   initial begin
      assert (NUM_PIRQ >= 1 && NUM_PIRQ <= LANES)
         else $error("NUM_PIRQ must fit in one configuration dword");
      assert (ROUTE_BASE[1:0] == 2'b00)
         else $error("ROUTE_BASE must be dword aligned");
   end

   logic wr_hit, rd_hit;
   logic [NUM_PIRQ-1:0][ROUTE_W-1:0] route_q;

   assign wr_hit = wr_en_i && (wr_addr_i[ADDR_W-1:2] == ROUTE_BASE[ADDR_W-1:2]);
   assign rd_hit = (rd_addr_i[ADDR_W-1:2] == ROUTE_BASE[ADDR_W-1:2]);

   for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_lane
      always_ff @(posedge clk_i) begin
         if (!rst_ni)
            route_q[p] <= ROUTE_RESET;
         else if (wr_hit && wr_be_i[p])
            route_q[p] <= wr_data_i[p*ROUTE_W +: ROUTE_W];
      end

      // R2/R3: a routing byte moves only under a matching, enabled write
      a_r2_lane_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !(wr_en_i && wr_be_i[p] &&
           wr_addr_i[ADDR_W-1:2] == ROUTE_BASE[ADDR_W-1:2]) |=> $stable(route_o[p]));
   end

   always_comb begin
      rd_data_o = '0;
      if (rd_hit) begin
         for (int p = 0; p < NUM_PIRQ; p++)
            rd_data_o[p*ROUTE_W +: ROUTE_W] = route_q[p];
      end
   end

   assign route_o = route_q;

endmodule

// File: rtl/pirq_level_map.sv
module pirq_level_map
   import pirq_router_pkg::*;
#(
   parameter int unsigned NUM_PIRQ  = 4,
   parameter int unsigned NUM_LINES = 16,
   localparam int unsigned LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
   localparam int unsigned MAP_W    = NUM_LINES * NUM_PIRQ
) (
   input  logic                              clk_i,
   input  logic                              rst_ni,
   input  logic [NUM_PIRQ-1:0][ROUTE_W-1:0]  route_i,
   input  logic [NUM_PIRQ-1:0]               level_i,
   output logic [MAP_W-1:0]                  map_o
);

   initial begin
      assert (NUM_LINES <= (1 << ROUTE_W))
         else $error("NUM_LINES exceeds the routing value range");
      assert ((1 << LINE_W) == NUM_LINES)
         else $error("NUM_LINES must be a power of two");
   end

   logic [NUM_PIRQ-1:0] enabled;
   logic [MAP_W-1:0]    map_d, map_q;

   for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_en
      assign enabled[p] = (int'(route_i[p]) < NUM_LINES);
   end

   // Bit (line*NUM_PIRQ + pirq) holds a level routed to that line
   for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_pirq
         assign map_d[l*NUM_PIRQ + p] = level_i[p] && enabled[p] &&
                                        (route_i[p][LINE_W-1:0] == LINE_W'(l));
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) map_q <= '0;
      else         map_q <= map_d;
   end

   assign map_o = map_q;

   for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_chk
      logic [NUM_LINES-1:0] column;
      for (genvar l = 0; l < NUM_LINES; l++) begin : g_col
         assign column[l] = map_q[l*NUM_PIRQ + p];
      end

      // R6: a disabled route leaves its column empty next cycle
      a_r6_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (int'(route_i[p]) >= NUM_LINES) |=> (column == '0));

      // R5: an enabled, high line sets the bit its route chose
      a_r5_routed_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ((int'(route_i[p]) < NUM_LINES) && level_i[p]) |=>
            map_q[int'($past(route_i[p][LINE_W-1:0]))*NUM_PIRQ + p]);

      // R5: one shared line reaches at most one output
      a_r5_one_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $countones(column) <= 1);
   end

endmodule

// File: rtl/pirq_pic_router.sv
module pirq_pic_router
   import pirq_router_pkg::*;
#(
   parameter int unsigned        NUM_PIRQ    = 4,
   parameter int unsigned        NUM_LINES   = 16,
   parameter int unsigned        ADDR_W      = 8,
   parameter logic [ADDR_W-1:0]  ROUTE_BASE  = 8'h60,
   parameter logic [7:0]         ROUTE_RESET = 8'h80,
   localparam int unsigned       MAP_W       = NUM_LINES * NUM_PIRQ,
   localparam int unsigned       PIRQ_W      = (NUM_PIRQ > 1) ? $clog2(NUM_PIRQ) : 1
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      cfg_wr_en_i,
   input  logic [ADDR_W-1:0]         cfg_wr_addr_i,
   input  logic [31:0]               cfg_wr_data_i,
   input  logic [3:0]                cfg_wr_be_i,
   input  logic [ADDR_W-1:0]         cfg_rd_addr_i,
   output logic [31:0]               cfg_rd_data_o,
   input  logic [NUM_PIRQ-1:0]       pirq_level_i,
   input  logic [7:0]                dev_devfn_i,
   input  logic [1:0]                dev_intx_i,
   output logic [PIRQ_W-1:0]         dev_pirq_o,
   output logic [NUM_LINES-1:0]      irq_o
);

   logic [NUM_PIRQ-1:0][ROUTE_W-1:0] route;
   logic [MAP_W-1:0]                 level_map;

   pirq_route_regs #(
      .NUM_PIRQ    (NUM_PIRQ),
      .ADDR_W      (ADDR_W),
      .ROUTE_BASE  (ROUTE_BASE),
      .ROUTE_RESET (ROUTE_RESET)
   ) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (cfg_wr_en_i),
      .wr_addr_i (cfg_wr_addr_i),
      .wr_data_i (cfg_wr_data_i),
      .wr_be_i   (cfg_wr_be_i),
      .rd_addr_i (cfg_rd_addr_i),
      .rd_data_o (cfg_rd_data_o),
      .route_o   (route)
   );

   pirq_level_map #(
      .NUM_PIRQ  (NUM_PIRQ),
      .NUM_LINES (NUM_LINES)
   ) u_map (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .route_i (route),
      .level_i (pirq_level_i),
      .map_o   (level_map)
   );

   // Wired-OR of every map bit belonging to a line
   for (genvar l = 0; l < NUM_LINES; l++) begin : g_out
      assign irq_o[l] = |level_map[l*NUM_PIRQ +: NUM_PIRQ];
   end

   // Slot swizzle: slot number is devfn[7:3]
   assign dev_pirq_o = PIRQ_W'(slot_to_pirq(int'(dev_devfn_i[7:3]),
                                            int'(dev_intx_i), NUM_PIRQ));

   // R7: no output without some input level in the cycle before
   a_r7_needs_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o != '0) |-> ($past(pirq_level_i) != '0));

endmodule

// File: tb/pirq_pic_router_tb_top.sv
module pirq_pic_router_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [7:0]  wr_addr;
   logic [31:0] wr_data;
   logic [3:0]  wr_be;
   logic [7:0]  rd_addr;
   logic [31:0] rd_data;
   logic [3:0]  lvl;
   logic [7:0]  devfn;
   logic [1:0]  intx;
   logic [1:0]  dpirq;
   logic [15:0] irq;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   pirq_pic_router dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .cfg_wr_en_i(wr_en), .cfg_wr_addr_i(wr_addr), .cfg_wr_data_i(wr_data),
      .cfg_wr_be_i(wr_be), .cfg_rd_addr_i(rd_addr), .cfg_rd_data_o(rd_data),
      .pirq_level_i(lvl), .dev_devfn_i(devfn), .dev_intx_i(intx),
      .dev_pirq_o(dpirq), .irq_o(irq)
   );

   // {routes D..A, levels D..A, expected outputs}
   localparam logic [51:0] VEC [7] = '{
      {32'h800A0505, 4'b0001, 16'h0020},   // R5 single route
      {32'h800A0505, 4'b0011, 16'h0020},   // R7 two lines share output 5
      {32'h800A0505, 4'b0100, 16'h0400},   // R5 line C to output 10
      {32'h800A0505, 4'b1000, 16'h0000},   // R6 line D disabled by 0x80
      {32'hFF100F00, 4'b1111, 16'h8001},   // R6 values 0x10, 0xFF disabled
      {32'h03030303, 4'b1111, 16'h0008},   // R7 all four on output 3
      {32'h02070100, 4'b0110, 16'h0082}    // R5 B->1, C->7
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; wr_be = 4'h0;
   endtask

   task automatic settle();
      @(posedge clk); @(posedge clk); @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; wr_be = '0;
      rd_addr = 8'h60; lvl = 4'hF; devfn = '0; intx = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 irq in reset", {16'h0, irq}, 32'h0);
      check("R1 routes in reset", rd_data, 32'h80808080);
      rst_n = 1'b1;
      settle();
      check("R1 irq after reset, levels high", {16'h0, irq}, 32'h0);
      check("R1 routes after reset", rd_data, 32'h80808080);
      lvl = 4'h0;

      // R2 byte lanes; address low bits ignored
      cfg_write(8'h62, 32'h11223344, 4'b0101);
      check("R2 partial lanes", rd_data, 32'h80228044);
      // R3 other dword
      cfg_write(8'h64, 32'h00000000, 4'b1111);
      check("R3 other dword write", rd_data, 32'h80228044);
      rd_addr = 8'h64; #1;
      check("R3 other dword read", rd_data, 32'h0);
      rd_addr = 8'h60;
      // R4 exact bytes
      cfg_write(8'h60, 32'hC78B1F4A, 4'b1111);
      check("R4 read back", rd_data, 32'hC78B1F4A);

      // table walk: R5 R6 R7
      for (int i = 0; i < 7; i++) begin
         cfg_write(8'h60, VEC[i][51:20], 4'hF);
         @(negedge clk); lvl = VEC[i][19:16];
         settle();
         check($sformatf("R5/R6/R7 vector %0d", i), {16'h0, irq}, {16'h0, VEC[i][15:0]});
      end
      lvl = 4'h0; settle();

      // R5 one-edge latency on a level change
      cfg_write(8'h60, 32'h80808002, 4'hF);
      @(negedge clk); lvl = 4'b0001;
      @(posedge clk); @(negedge clk);
      check("R5 latency", {16'h0, irq}, 32'h0004);

      // R8 reroute A from 2 to 9
      cfg_write(8'h60, 32'h80808009, 4'b0001);
      check("R8 old route one edge after store", {16'h0, irq}, 32'h0004);
      @(posedge clk); @(negedge clk);
      check("R8 new route second edge", {16'h0, irq}, 32'h0200);

      // R6 disable while high
      cfg_write(8'h60, 32'h80808010, 4'b0001);
      settle();
      check("R6 disabled while high", {16'h0, irq}, 32'h0);

      // R7 wired-OR drop order
      cfg_write(8'h60, 32'h80800505, 4'hF);
      @(negedge clk); lvl = 4'b0011; settle();
      lvl = 4'b0010; settle();
      check("R7 one sharer left", {16'h0, irq}, 32'h0020);
      lvl = 4'b0000; settle();
      check("R7 all sharers low", {16'h0, irq}, 32'h0);

      // R9 slot swizzle
      devfn = 8'h08; intx = 2'd0; #1; check("R9 slot1 pin0", {30'h0, dpirq}, 32'd0);
      devfn = 8'h08; intx = 2'd3; #1; check("R9 slot1 pin3", {30'h0, dpirq}, 32'd3);
      devfn = 8'h00; intx = 2'd0; #1; check("R9 slot0 pin0", {30'h0, dpirq}, 32'd3);
      devfn = 8'h2D; intx = 2'd2; #1; check("R9 slot5 pin2", {30'h0, dpirq}, 32'd2);
      devfn = 8'hF8; intx = 2'd1; #1; check("R9 slot31 pin1", {30'h0, dpirq}, 32'd3);

      // R1 reset restores defaults
      @(negedge clk); lvl = 4'hF; rst_n = 1'b0;
      @(posedge clk); @(negedge clk);
      check("R1 routes restored", rd_data, 32'h80808080);
      check("R1 map cleared", {16'h0, irq}, 32'h0);
      rst_n = 1'b1;
      finish_run();
   end

endmodule